// File: doc/BRIEF.md
# Interrupt Entry Injector

This block sits between the opcode-fetch path and the instruction register of a small 8-bit accumulator CPU. On every opcode-fetch cycle it decides whether the byte that comes back from memory goes into the instruction register, or whether a forced break opcode takes its place. When a hardware interrupt (the reset line, an NMI edge or an unmasked IRQ level) is pending at the fetch, the fetched byte is dropped, `0x00` is loaded instead, and the program-counter step is withheld. The PC that is later stacked therefore still points at the dropped opcode, and that opcode is fetched again after the return.

All entry kinds use one path and differ only in the vector. The winning source is captured at the fetch. A fixed-length entry window then follows. In that window the block requests the vector low and high bytes, provides the break-flag value for the stacked status, turns the stack pushes into reads when the source is reset, and signals the end of the window so the core can set its interrupt mask.

Top module: `intr_inject`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ir_data` is 0x00, and `busy`, `vec_rd`, `stack_rd_only`, `mask_set` and `brk_bit` are 0.
- R2: A fetch with no source pending gives `pc_step`=1 in the fetch cycle and loads `fetch_data` into `ir_data` at that clock edge.
- R3: A fetch with a hardware source pending gives `pc_step`=0 in the fetch cycle and loads 0x00 into `ir_data`, whatever the value of `fetch_data`.
- R4: A low `irq_n` is ignored while `irq_mask` is 1. The fetch passes through with `pc_step`=1.
- R5: A falling edge on `nmi_n` is held pending, even after the line returns high, until that NMI has been serviced. The NMI is serviced once per edge, and a line held low does not trigger it again.
- R6: The priority order is reset (`res_n` low), then pending NMI, then unmasked IRQ. Their vector low addresses are 0xFFFC, 0xFFFA and 0xFFFE. A pending NMI that loses to reset stays pending.
- R7: In the entry window, cycle 1 is the fetch and `busy` is high in cycles 2 to 7. `vec_rd` is high only in cycles 6 and 7. `vec_addr` gives the low address in cycle 6 and the low address plus 1 in cycle 7.
- R8: Once a fetch has begun an entry window, later changes on `res_n` and `irq_n` do not change the vector addresses of that window.
- R9: A fetched 0x00 with no hardware source pending is a software break. It uses vector 0xFFFE, gives `pc_step`=1 and `brk_bit`=1 throughout its window. `brk_bit` is 0 for every hardware entry.
- R10: `stack_rd_only` is high in cycles 3 to 5 (the three push slots) only when the source is reset.
- R11: `mask_set` pulses for exactly one cycle, in cycle 7 of every entry window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| res_n | input | 1 | CPU reset request, active low, level sensitive |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| irq_mask | input | 1 | Interrupt-disable flag from the status register |
| fetch_cyc | input | 1 | High during an opcode-fetch cycle |
| fetch_data | input | 8 | Opcode byte returned by memory |
| ir_data | output | 8 | Instruction register contents |
| pc_step | output | 1 | Program counter may increment in this fetch cycle |
| vec_addr | output | 16 | Vector byte address |
| vec_rd | output | 1 | Vector byte read request |
| brk_bit | output | 1 | Break-flag value for the pushed status |
| busy | output | 1 | Entry window in progress (cycles 2 to 7) |
| stack_rd_only | output | 1 | Turn the push cycles into reads (reset entry) |
| mask_set | output | 1 | Set the interrupt-disable flag at window end |

## Verification
The assertions assume that the core never raises `fetch_cyc` while `busy` is high, and that every input changes only between rising edges. The bench drives all inputs on the falling edge and keeps `fetch_cyc` low for the whole entry window. Its task drops `res_n` and `irq_n` right after each capturing fetch, so every window is also a test of vector stability. NMI edges are made one cycle before the fetch so that the pending flop has already captured them.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BRK  = 3'd1,
    SRC_IRQ  = 3'd2,
    SRC_NMI  = 3'd3,
    SRC_RES  = 3'd4
  } src_e;
endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      if (fall)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int          DW     = 8,
  parameter logic [DW-1:0] BRK_OP = '0
) (
  input  logic          res_n,
  input  logic          nmi_pend,
  input  logic          irq_n,
  input  logic          irq_mask,
  input  logic [DW-1:0] fetch_data,
  output src_e          pick,
  output logic          hw
);
  always_comb begin
    if (!res_n)                     pick = SRC_RES;
    else if (nmi_pend)              pick = SRC_NMI;
    else if (!irq_n && !irq_mask)   pick = SRC_IRQ;
    else if (fetch_data == BRK_OP)  pick = SRC_BRK;
    else                            pick = SRC_NONE;
  end

  assign hw = (pick == SRC_RES) || (pick == SRC_NMI) || (pick == SRC_IRQ);
endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
  import intr_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            ENTRY_LEN = 7,
  parameter logic [AW-1:0] VEC_BASE  = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  src_e          src_in,
  output logic          busy,
  output logic          vec_rd,
  output logic [AW-1:0] vec_addr,
  output logic          brk_bit,
  output logic          stack_rd_only,
  output logic          mask_set,
  output logic          nmi_done
);
  localparam int CW         = $clog2(ENTRY_LEN + 1);
  localparam int LO_CYC     = ENTRY_LEN - 1;
  localparam int HI_CYC     = ENTRY_LEN;
  localparam int PUSH_FIRST = 3;
  localparam int PUSH_LAST  = ENTRY_LEN - 2;

  logic [CW-1:0] cyc_q;
  src_e          src_q;
  logic [AW-1:0] lo_addr;
  logic          at_lo, at_hi, in_push;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      src_q <= SRC_NONE;
    end else if (start) begin
      cyc_q <= CW'(2);
      src_q <= src_in;
    end else if (cyc_q == CW'(HI_CYC)) begin
      cyc_q <= '0;
      src_q <= SRC_NONE;
    end else if (cyc_q != '0) begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  always_comb begin
    lo_addr = VEC_BASE;
    if (src_q == SRC_RES)      lo_addr[1] = 1'b0;
    else if (src_q == SRC_NMI) lo_addr[2] = 1'b0;
  end

  assign at_lo   = (cyc_q == CW'(LO_CYC));
  assign at_hi   = (cyc_q == CW'(HI_CYC));
  assign in_push = (cyc_q >= CW'(PUSH_FIRST)) && (cyc_q <= CW'(PUSH_LAST));

  assign busy          = (cyc_q != '0);
  assign vec_rd        = at_lo | at_hi;
  assign vec_addr      = at_hi ? (lo_addr | AW'(1)) : lo_addr;
  assign brk_bit       = busy && (src_q == SRC_BRK);
  assign stack_rd_only = in_push && (src_q == SRC_RES);
  assign mask_set      = at_hi;
  assign nmi_done      = at_hi && (src_q == SRC_NMI);
endmodule

// File: rtl/intr_inject.sv
module intr_inject
  import intr_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            AW        = 16,
  parameter int            ENTRY_LEN = 7,
  parameter logic [AW-1:0] VEC_BASE  = 16'hFFFE,
  parameter logic [DW-1:0] BRK_OP    = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_n,
  input  logic          nmi_n,
  input  logic          irq_n,
  input  logic          irq_mask,
  input  logic          fetch_cyc,
  input  logic [DW-1:0] fetch_data,
  output logic [DW-1:0] ir_data,
  output logic          pc_step,
  output logic [AW-1:0] vec_addr,
  output logic          vec_rd,
  output logic          brk_bit,
  output logic          busy,
  output logic          stack_rd_only,
  output logic          mask_set
);
  logic nmi_pend, nmi_done, hw, fetch_ok, start;
  src_e pick;

  intr_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .clr(nmi_done), .pend(nmi_pend)
  );

  intr_arbiter #(.DW(DW), .BRK_OP(BRK_OP)) u_arb (
    .res_n(res_n), .nmi_pend(nmi_pend), .irq_n(irq_n), .irq_mask(irq_mask),
    .fetch_data(fetch_data), .pick(pick), .hw(hw)
  );

  assign fetch_ok = fetch_cyc && !busy;
  assign start    = fetch_ok && (pick != SRC_NONE);
  assign pc_step  = fetch_ok && !hw;

  intr_sequencer #(.AW(AW), .ENTRY_LEN(ENTRY_LEN), .VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst(rst), .start(start), .src_in(pick), .busy(busy),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .brk_bit(brk_bit),
    .stack_rd_only(stack_rd_only), .mask_set(mask_set), .nmi_done(nmi_done)
  );

  always_ff @(posedge clk) begin
    if (rst)           ir_data <= '0;
    else if (fetch_ok) ir_data <= hw ? BRK_OP : fetch_data;
  end
endmodule

// File: rtl/intr_inject_chk.sv
module intr_inject_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          res_n,
  input logic          fetch_cyc,
  input logic [DW-1:0] fetch_data,
  input logic [DW-1:0] ir_data,
  input logic          pc_step,
  input logic [AW-1:0] vec_addr,
  input logic          vec_rd,
  input logic          brk_bit,
  input logic          busy,
  input logic          stack_rd_only,
  input logic          mask_set
);
  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    (fetch_cyc && !busy && pc_step) |=> (ir_data == $past(fetch_data)));

  a_r3_reset_injects: assert property (@(posedge clk) disable iff (rst)
    (fetch_cyc && !busy && !res_n) |-> !pc_step);

  a_r3_forced_opcode: assert property (@(posedge clk) disable iff (rst)
    (fetch_cyc && !busy && !pc_step) |=> (ir_data == '0 && busy));

  a_r7_vec_in_window: assert property (@(posedge clk) disable iff (rst)
    vec_rd |-> busy);

  a_r7_hi_follows_lo: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !vec_addr[0]) |=> (vec_rd && vec_addr[0] && $stable(vec_addr[AW-1:1])));

  a_r11_mask_ends_window: assert property (@(posedge clk) disable iff (rst)
    mask_set |=> !busy);

  a_r10_read_only_reset: assert property (@(posedge clk) disable iff (rst)
    stack_rd_only |-> (busy && !brk_bit && !vec_rd));

  a_r9_brk_in_window: assert property (@(posedge clk) disable iff (rst)
    brk_bit |-> busy);
endmodule

bind intr_inject intr_inject_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .res_n(res_n), .fetch_cyc(fetch_cyc),
  .fetch_data(fetch_data), .ir_data(ir_data), .pc_step(pc_step),
  .vec_addr(vec_addr), .vec_rd(vec_rd), .brk_bit(brk_bit), .busy(busy),
  .stack_rd_only(stack_rd_only), .mask_set(mask_set)
);

// File: tb/sim_intr_inject.sv
`timescale 1ns/1ps
module sim_intr_inject;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, irq_mask = 1'b0;
  logic        fetch_cyc = 1'b0;
  logic [7:0]  fetch_data = 8'hEA;
  logic [7:0]  ir_data;
  logic        pc_step, vec_rd, brk_bit, busy, stack_rd_only, mask_set;
  logic [15:0] vec_addr;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intr_inject u0 (
    .clk(clk), .rst(rst), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
    .irq_mask(irq_mask), .fetch_cyc(fetch_cyc), .fetch_data(fetch_data),
    .ir_data(ir_data), .pc_step(pc_step), .vec_addr(vec_addr), .vec_rd(vec_rd),
    .brk_bit(brk_bit), .busy(busy), .stack_rd_only(stack_rd_only), .mask_set(mask_set)
  );

  // source codes: 0 pass, 1 software break, 2 IRQ, 3 NMI, 4 reset
  // row: {res_n, irq_n, irq_mask, opcode[7:0], src[2:0]}
  localparam logic [13:0] TBL [8] = '{
    {1'b1, 1'b1, 1'b0, 8'hA9, 3'd0},
    {1'b1, 1'b0, 1'b0, 8'hA9, 3'd2},
    {1'b1, 1'b0, 1'b1, 8'hA9, 3'd0},
    {1'b1, 1'b1, 1'b0, 8'h00, 3'd1},
    {1'b0, 1'b0, 1'b0, 8'hA9, 3'd4},
    {1'b0, 1'b1, 1'b1, 8'h4C, 3'd4},
    {1'b1, 1'b0, 1'b1, 8'h00, 3'd1},
    {1'b1, 1'b0, 1'b0, 8'h00, 3'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Starts just after a falling edge; returns just after a falling edge.
  task automatic run_fetch(input logic r, input logic q, input logic m,
                           input logic [7:0] op, input int src, input string tag);
    logic [15:0] lo;
    bit ent, rdonly, brk;
    ent    = (src != 0);
    rdonly = (src == 4);
    brk    = (src == 1);
    lo     = (src == 4) ? 16'hFFFC : (src == 3) ? 16'hFFFA : 16'hFFFE;
    res_n = r; irq_n = q; irq_mask = m; fetch_data = op; fetch_cyc = 1'b1;
    #1;
    chk(pc_step == (src <= 1), (src <= 1) ? "R2" : "R3", {tag, " pc_step"}, 32'(pc_step), 32'(src <= 1));
    @(negedge clk);
    fetch_cyc = 1'b0; res_n = 1'b1; irq_n = 1'b1; fetch_data = 8'hFF; // R8 disturbance
    #1;
    chk(ir_data == ((src >= 1) ? 8'h00 : op), "R3", {tag, " ir_data"}, 32'(ir_data),
        32'((src >= 1) ? 8'h00 : op));
    if (!ent) begin
      chk(busy == 1'b0, "R2", {tag, " no window"}, 32'(busy), 0);
      return;
    end
    for (int k = 2; k <= 7; k++) begin
      chk(busy == 1'b1, "R7", {tag, " busy"}, 32'(busy), 1);
      chk(vec_rd == (k >= 6), "R7", {tag, " vec_rd"}, 32'(vec_rd), 32'(k >= 6));
      if (k == 6) chk(vec_addr == lo, "R6", {tag, " vec lo R8"}, 32'(vec_addr), 32'(lo));
      if (k == 7) chk(vec_addr == (lo | 16'h1), "R7", {tag, " vec hi R8"}, 32'(vec_addr), 32'(lo | 16'h1));
      chk(stack_rd_only == (rdonly && k >= 3 && k <= 5), "R10", {tag, " stack_rd_only"},
          32'(stack_rd_only), 32'(rdonly && k >= 3 && k <= 5));
      chk(mask_set == (k == 7), "R11", {tag, " mask_set"}, 32'(mask_set), 32'(k == 7));
      chk(brk_bit == brk, "R9", {tag, " brk_bit"}, 32'(brk_bit), 32'(brk));
      @(negedge clk); #1;
    end
    chk(busy == 1'b0, "R7", {tag, " window end"}, 32'(busy), 0);
    #1;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    fetch_cyc = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(ir_data == 8'h00 && !busy && !vec_rd && !stack_rd_only && !mask_set && !brk_bit,
        "R1", "state during reset", {24'h0, ir_data}, 0);
    fetch_cyc = 1'b0;
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!busy && !vec_rd && !brk_bit && ir_data == 8'h00, "R1", "state after reset",
        {24'h0, ir_data}, 0);
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_fetch(TBL[i][13], TBL[i][12], TBL[i][11], TBL[i][10:3], int'(TBL[i][2:0]),
                $sformatf("row%0d", i));
    end

    // R5: edge latched, line back high before fetch; NMI beats IRQ (R6)
    nmi_n = 1'b0; @(negedge clk); nmi_n = 1'b1; @(negedge clk);
    run_fetch(1'b1, 1'b0, 1'b0, 8'hA9, 3, "R5 nmi over irq");
    run_fetch(1'b1, 1'b1, 1'b0, 8'h85, 0, "R5 serviced once");
    // R5: held low, no retrigger
    nmi_n = 1'b0; @(negedge clk);
    run_fetch(1'b1, 1'b1, 1'b0, 8'h85, 3, "R5 held low first");
    run_fetch(1'b1, 1'b1, 1'b0, 8'h85, 0, "R5 held low no retrigger");
    nmi_n = 1'b1; @(negedge clk);
    // R6: reset beats NMI, NMI stays pending
    nmi_n = 1'b0; @(negedge clk);
    run_fetch(1'b0, 1'b1, 1'b0, 8'h85, 4, "R6 reset over nmi");
    run_fetch(1'b1, 1'b1, 1'b0, 8'h85, 3, "R6 nmi kept pending");
    nmi_n = 1'b1; @(negedge clk);
    // R4: masked IRQ with other opcode
    run_fetch(1'b1, 1'b0, 1'b1, 8'h18, 0, "R4 masked irq");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule